// File: doc/BRIEF.md
# Dynamic 16-bit Bus Sizing Sequencer

This block sits between a requester that issues 32-bit bus transfers and an external bus that can answer any cycle as narrow, meaning only data lines 15..0 carried data. The requester hands over an address, four byte enables, a direction and write data. The sequencer runs the bus cycle. When the cycle ends, it samples the narrow-size input together with ready.

A narrow answer may come while enabled bytes are still waiting in both halves of the word. In that case the sequencer runs a dependent second cycle. That cycle keeps the same address and direction. Its lower byte enables are forced off. For a write, the upper-half write bytes are steered onto lines 15..0. For a read, the two halves are stitched together, and the requester sees a single completion carrying the assembled word.

The block also arbitrates address pipelining. A next-address request raised by the bus is granted only while the narrow-size input is low. Once a grant has been given in a cycle, that cycle can no longer be repeated as a 16-bit transfer.

Top module: `bus_sizer`

## Requirements
- R1: After reset `bus_cyc`, `done` and `pipe_grant` are low and `req_ready` is high.
- R2: A request taken while `req_ready` is high starts a bus cycle on the next clock. That cycle drives the request's address, byte enables, direction and write data unchanged.
- R3: A cycle that ends with `bus_ready` high and `bus_narrow` low completes the request. `done` is high for the following clock, with `rsp_data` equal to the full `bus_rdata` seen with ready.
- R4: When a first cycle ends with `bus_narrow` high and at least one byte enabled in each half, a second cycle follows. The lower half is byte enables 1:0 and the upper half is 3:2. The second cycle uses the same address and direction, with byte enables 1:0 forced to 0 and 3:2 kept.
- R5: If only byte enables 1:0, or only 3:2, are set, a narrow answer ends the request after one cycle.
- R6: During the second cycle of a write, `bus_wdata[15:0]` carries the request's write bits 31:16, and bits 31:16 are unchanged.
- R7: For a read that needed two cycles, `rsp_data[15:0]` is `bus_rdata[15:0]` from the first cycle. `rsp_data[31:16]` is `bus_rdata[15:0]` from the second cycle.
- R8: Each request yields exactly one `done` pulse of one clock, raised only after the last required cycle has been acknowledged.
- R9: `pipe_grant` is high in a clock only when a cycle is active, `bus_next` is high, `bus_narrow` is low and no grant has yet been given in that cycle. With `bus_next` and `bus_narrow` both high at the final ready, the narrow size wins: a second cycle runs and no grant is given.
- R10: After a grant in a first cycle, a narrow answer at that cycle's ready does not produce a second cycle.
- R11: `bus_narrow` has no effect in a wait clock (ready low) or during a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester offers a transfer |
| req_addr | input | AW | Transfer address |
| req_be | input | DW/8 | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| done | output | 1 | One-clock completion pulse |
| rsp_data | output | DW | Assembled read data, valid with done |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_addr | output | AW | Cycle address |
| bus_be | output | DW/8 | Cycle byte enables |
| bus_write | output | 1 | Cycle direction |
| bus_wdata | output | DW | Cycle write data |
| bus_rdata | input | DW | Read data from the bus |
| bus_ready | input | 1 | Cycle acknowledge |
| bus_narrow | input | 1 | Cycle answered by a 16-bit port |
| bus_next | input | 1 | Bus asks for the next address early |
| pipe_grant | output | 1 | Next address may be issued |

## Verification
The assertions assume that the bus raises `bus_ready` only while `bus_cyc` is high. They also assume that the requester holds `req_valid` no longer than the clock in which it is taken. The bench keeps within both: it raises ready only in cycles it has already seen start, and it drops `req_valid` right after the taking edge. Narrow and next-address inputs are driven freely in wait clocks and second cycles, because the design must ignore them there.

// File: rtl/bus_sizer_pkg.sv
// Shared types for the bus sizing sequencer.
package bus_sizer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } sz_phase_e;
endpackage

// File: rtl/sz_lanes.sv
// Byte-lane rewriting for the active bus cycle.
// Forces the lower enables off in a second cycle, steers the upper write
// half onto the lower lines then, and reports whether both halves have
// enabled bytes. Assumes DW is a multiple of 16.
module sz_lanes
    import bus_sizer_pkg::*;
#(
    parameter int DW = 32
) (
    input  sz_phase_e         phase,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     wdata,
    output logic [DW/8-1:0]   bus_be,
    output logic [DW-1:0]     bus_wdata,
    output logic              both_halves
);
    localparam int BEW = DW / 8;
    localparam int HBE = BEW / 2;
    localparam int HW  = DW / 2;

    // Half-occupancy test used for the second-cycle decision.
    always_comb both_halves = (|be[HBE-1:0]) && (|be[BEW-1:HBE]);

    // Per-lane enable masking; lower lanes live only in the first cycle.
    for (genvar i = 0; i < BEW; i++) begin : g_lane
        if (i < HBE) begin : g_lo
            always_comb bus_be[i] = be[i] && (phase == PH_FIRST);
        end else begin : g_hi
            always_comb bus_be[i] = be[i] && (phase != PH_IDLE);
        end
    end

    // Write data steering: upper half copied down in the second cycle.
    always_comb begin
        bus_wdata = wdata;
        if (phase == PH_SECOND) bus_wdata[HW-1:0] = wdata[DW-1:HW];
    end
endmodule

// File: rtl/sz_merge.sv
// Read data assembly. Holds the low half from a first cycle that is
// followed by a second one, and builds the returned word at completion.
// Assumes the strobes are mutually exclusive.
module sz_merge #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_lo,
    input  logic          fin_full,
    input  logic          fin_merge,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] rsp_data
);
    localparam int HW = DW / 2;

    logic [HW-1:0] lo_q;

    // Capture the low half and form the response word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            rsp_data <= '0;
        end else begin
            if (cap_lo)    lo_q     <= bus_rdata[HW-1:0];
            if (fin_full)  rsp_data <= bus_rdata;
            if (fin_merge) rsp_data <= {bus_rdata[HW-1:0], lo_q};
        end
    end
endmodule

// File: rtl/sz_ctrl.sv
// Cycle sequencing: idle, first cycle, optional second cycle.
// Samples the narrow size only with ready in a first cycle, arbitrates
// next-address grants, and emits one done pulse per request.
// Assumes bus_ready is only raised while a cycle is active.
module sz_ctrl
    import bus_sizer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      both_halves,
    input  logic      bus_ready,
    input  logic      bus_narrow,
    input  logic      bus_next,
    output sz_phase_e phase,
    output logic      req_take,
    output logic      pipe_grant,
    output logic      cap_lo,
    output logic      fin_full,
    output logic      fin_merge,
    output logic      done
);
    logic committed;
    logic active;
    logic go_second;
    logic fin;

    // Decode of the current clock's events.
    always_comb begin
        active     = (phase != PH_IDLE);
        req_take   = (phase == PH_IDLE) && req_valid;
        pipe_grant = active && !committed && bus_next && !bus_narrow;
        go_second  = (phase == PH_FIRST) && bus_ready && bus_narrow
                     && both_halves && !committed;
        fin        = active && bus_ready && !go_second;
        cap_lo     = go_second;
        fin_full   = fin && (phase == PH_FIRST);
        fin_merge  = fin && (phase == PH_SECOND);
    end

    // Phase, commit flag and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            committed <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= fin;
            if (fin || go_second)  committed <= 1'b0;
            else if (pipe_grant)   committed <= 1'b1;
            if (req_take)          phase <= PH_FIRST;
            else if (go_second)    phase <= PH_SECOND;
            else if (fin)          phase <= PH_IDLE;
        end
    end

    // R8: completion never lasts more than one clock
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: wide acknowledge of a first cycle completes the request
    a_r3_wide_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && bus_ready && !bus_narrow) |=> (done && phase == PH_IDLE));

    // R5: single-half request never repeats
    a_r5_single_half: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && bus_ready && !both_halves) |=> (phase == PH_IDLE));

    // R10: a granted cycle is not repeated
    a_r10_commit_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && $past(pipe_grant) && bus_ready) |=> (phase == PH_IDLE));

    // R11: a second cycle ends on its ready whatever the narrow input says
    a_r11_second_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SECOND && bus_ready) |=> (phase == PH_IDLE && done));
endmodule

// File: rtl/bus_sizer.sv
// Top of the dynamic 16-bit bus sizing sequencer.
// Latches one request, runs one or two bus cycles for it, and returns a
// single completion with assembled read data.
// Assumes requests arrive only when req_ready is high.
module bus_sizer
    import bus_sizer_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW/8-1:0] req_be,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ready,
    output logic            done,
    output logic [DW-1:0]   rsp_data,
    output logic            bus_cyc,
    output logic [AW-1:0]   bus_addr,
    output logic [DW/8-1:0] bus_be,
    output logic            bus_write,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ready,
    input  logic            bus_narrow,
    input  logic            bus_next,
    output logic            pipe_grant
);
    localparam int BEW = DW / 8;
    localparam int HBE = BEW / 2;

    sz_phase_e      phase;
    logic           req_take;
    logic           both_halves;
    logic           cap_lo;
    logic           fin_full;
    logic           fin_merge;
    logic [AW-1:0]  addr_q;
    logic [BEW-1:0] be_q;
    logic           wr_q;
    logic [DW-1:0]  wd_q;

    // Request holding registers, loaded when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
        end else if (req_take) begin
            addr_q <= req_addr;
            be_q   <= req_be;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
        end
    end

    // Bus-side and requester-side status outputs.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        bus_cyc   = (phase != PH_IDLE);
        bus_addr  = addr_q;
        bus_write = wr_q;
    end

    sz_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .both_halves(both_halves),
        .bus_ready  (bus_ready),
        .bus_narrow (bus_narrow),
        .bus_next   (bus_next),
        .phase      (phase),
        .req_take   (req_take),
        .pipe_grant (pipe_grant),
        .cap_lo     (cap_lo),
        .fin_full   (fin_full),
        .fin_merge  (fin_merge),
        .done       (done)
    );

    sz_lanes #(.DW(DW)) u_lanes (
        .phase      (phase),
        .be         (be_q),
        .wdata      (wd_q),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .both_halves(both_halves)
    );

    sz_merge #(.DW(DW)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_lo   (cap_lo),
        .fin_full (fin_full),
        .fin_merge(fin_merge),
        .bus_rdata(bus_rdata),
        .rsp_data (rsp_data)
    );

    // R4: address and direction hold across the whole transaction
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> ($stable(bus_addr) && $stable(bus_write)));

    // R4: lower enables are off in any second cycle
    a_r4_lower_off: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SECOND) |-> (bus_be[HBE-1:0] == '0));

    // R2: a taken request starts a cycle on the next clock
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> bus_cyc);
endmodule

// File: tb/tb_bus_sizer.sv
// Self-checking bench: a behavioural model of each transaction predicts
// every clock's bus and response outputs.
module tb_bus_sizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done, bus_cyc, bus_write, pipe_grant;
    logic [31:0] rsp_data, bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0, bus_narrow = 1'b0, bus_next = 1'b0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    bus_sizer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rsp_data(rsp_data),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_narrow(bus_narrow), .bus_next(bus_next),
        .pipe_grant(pipe_grant)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transaction; the model decides the cycle count and the response.
    task automatic txn(input logic [31:0] a, input logic [3:0] be, input bit wr,
                       input logic [31:0] wd, input int nwait, input bit wnext,
                       input bit wnarrow, input bit fnarrow, input bit fnext,
                       input logic [31:0] rd1, input logic [31:0] rd2);
        bit committed = 0;
        bit both = (|be[1:0]) && (|be[3:2]);
        bit second;
        logic [31:0] exp_rsp;
        chk(req_ready == 1'b1, "R8 idle before request", {31'b0, req_ready}, 32'h1);
        req_valid = 1; req_addr = a; req_be = be; req_write = wr; req_wdata = wd;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_addr = '0; req_be = '0; req_wdata = '0;
        chk(bus_cyc && bus_addr == a, "R2 first addr", bus_addr, a);
        chk(bus_be == be && bus_write == wr, "R2 first be/dir", {27'b0, bus_write, bus_be}, {27'b0, wr, be});
        if (wr) chk(bus_wdata == wd, "R2 first wdata", bus_wdata, wd);
        for (int w = 0; w < nwait; w++) begin
            bus_ready = 0; bus_next = wnext; bus_narrow = wnarrow; #1;
            chk(pipe_grant == (wnext && !wnarrow && !committed), "R9 grant in wait",
                {31'b0, pipe_grant}, {31'b0, wnext && !wnarrow && !committed});
            if (wnext && !wnarrow) committed = 1;
            @(posedge clk); @(negedge clk);
            chk(done == 0 && bus_cyc, "R11 wait keeps cycle", {31'b0, done}, 32'h0);
        end
        bus_ready = 1; bus_narrow = fnarrow; bus_next = fnext; bus_rdata = rd1; #1;
        chk(pipe_grant == (fnext && !fnarrow && !committed), "R9 grant at ready",
            {31'b0, pipe_grant}, {31'b0, fnext && !fnarrow && !committed});
        second = fnarrow && both && !committed;
        @(posedge clk); @(negedge clk);
        bus_ready = 0; bus_narrow = 0; bus_next = 0; bus_rdata = '0;
        if (second) begin
            chk(done == 0, "R8 no done before second", {31'b0, done}, 32'h0);
            chk(bus_cyc && bus_addr == a && bus_write == wr, "R4 second addr", bus_addr, a);
            chk(bus_be == {be[3:2], 2'b00}, "R4 second be", {28'b0, bus_be}, {28'b0, be[3:2], 2'b00});
            if (wr) chk(bus_wdata == {wd[31:16], wd[31:16]}, "R6 second wdata",
                        bus_wdata, {wd[31:16], wd[31:16]});
            bus_ready = 1; bus_narrow = 1; bus_rdata = rd2;
            @(posedge clk); @(negedge clk);
            bus_ready = 0; bus_narrow = 0; bus_rdata = '0;
            exp_rsp = {rd2[15:0], rd1[15:0]};
        end else begin
            exp_rsp = rd1;
        end
        chk(done == 1, "R8 done after last ready", {31'b0, done}, 32'h1);
        if (!wr) chk(rsp_data == exp_rsp, second ? "R7 merged read" : "R3 full read", rsp_data, exp_rsp);
        chk(bus_cyc == 0, "R5 R10 R11 cycle count", {31'b0, bus_cyc}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk(done == 0, "R8 single pulse", {31'b0, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk(!bus_cyc && !done && !pipe_grant && req_ready, "R1 reset state",
            {28'b0, bus_cyc, done, pipe_grant, req_ready}, 32'h1);
        // R3 wide write, no waits
        txn(32'h0000_1000, 4'b1111, 1, 32'hA1B2_C3D4, 0, 0, 0, 0, 0, '0, '0);
        // R4 R7 narrow read with one wait
        txn(32'h0000_2004, 4'b1111, 0, '0, 1, 0, 0, 1, 0, 32'h1111_5678, 32'h2222_9ABC);
        // R4 R6 narrow write
        txn(32'h0000_3008, 4'b1111, 1, 32'hDEAD_BEEF, 0, 0, 0, 1, 0, '0, '0);
        // R5 lower-only and upper-only narrow reads
        txn(32'h0000_400C, 4'b0011, 0, '0, 0, 0, 0, 1, 0, 32'h3333_4444, '0);
        txn(32'h0000_5010, 4'b1100, 0, '0, 0, 0, 0, 1, 0, 32'h5555_6666, '0);
        // R9 narrow and next together at ready: narrow wins
        txn(32'h0000_6014, 4'b1111, 0, '0, 0, 0, 0, 1, 1, 32'h7777_0001, 32'h8888_0002);
        // R10 grant in wait, then narrow at ready gives no second cycle
        txn(32'h0000_7018, 4'b1111, 0, '0, 2, 1, 0, 1, 0, 32'h9999_AAAA, '0);
        // R11 narrow in waits ignored, second cycle for middle bytes
        txn(32'h0000_801C, 4'b0110, 0, '0, 2, 0, 1, 1, 0, 32'hBBBB_CCCC, 32'hDDDD_EEEE);
        // R9 grant given at a wide ready
        txn(32'h0000_9020, 4'b1111, 0, '0, 0, 0, 0, 0, 1, 32'hFEDC_BA98, '0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule